// File: doc/BRIEF.md
# Four-Channel Trigger-Latched PWM Generator

The block drives four pulse-width-modulated outputs from one input clock. Software reaches it through a small memory-mapped register port. Writes take effect on the next clock edge. Reads are combinational and return the value held in the addressed register.

Each channel has four programmable settings: a period count, a duty count, a prescaler and a polarity. The period count, duty count and prescaler are staged in shadow registers, and a running channel ignores them. A channel copies its shadow settings into its working registers only when software lowers that channel's trigger bit, keeps it low for a qualified minimum time, then raises it and keeps it high for the same minimum time. A trigger that does not meet both windows is discarded. Polarity and the output-type selection act directly on the pins.

The usual way to change a channel is this sequence: clear its trigger bit, write the new counts, then set the trigger bit again. To park a channel, software loads zeros into its period, duty and prescaler and then triggers it.

Top module: `pwm_trig_bank`

## Requirements
- R1: Register map, using byte addresses on `addr_i`.
  - Control is at 0x00. Channel n has its trigger bit at bit n, its polarity bit at bit 8+n and its output-type bit at bit 15+n.
  - The period of channel n is at 0x04+8n and its duty at 0x08+8n. Both are 16 bits wide.
  - The prescaler register is at 0x24.
  - Any other address reads as 0.
  - After reset every register reads 0, except that the polarity bits read 1, so control reads 0x00000F00.
- R2: The prescaler register holds four 6-bit fields. The field for channel n starts at bit (3-n)*6, so channel 0 occupies bits 23:18 and channel 3 occupies bits 5:0.
- R3: Period, duty and prescaler writes change the shadow registers only. A running channel's waveform does not change until a trigger is accepted, even when its trigger bit is already high at the time of the write.
- R4: A trigger is accepted only under two conditions. First, the trigger bit was low for at least HOLD_CYC consecutive clocks before it rose. Second, it then stays high for HOLD_CYC clocks. If the low time or the high time is too short, the trigger is discarded and the working settings are kept.
- R5: For a latched period P≠0, duty D and prescaler S, the waveform repeats every (S+1)·P clocks and is active for (S+1)·D clocks of each repetition. When a trigger is accepted, both counters restart from zero.
- R6: If D ≥ P, with P≠0, the output stays active continuously. If D = 0, the output stays inactive continuously.
- R7: A latched period of 0 puts the channel in the idle state, where its output is held at the inactive level.
- R8: A polarity bit of 1 makes the output high while active. A polarity bit of 0 inverts the output, so it is low while active and high while inactive. A polarity change takes effect on the next clock.
- R9: `drive_full_o[n]` is 1 exactly when the output-type bit of channel n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; also the PWM time base |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe, one clock per write |
| addr_i | input | 6 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pwm_o | output | 4 | PWM outputs, one per channel |
| drive_full_o | output | 4 | Per-channel drive-mode indication, 1 = full drive |

## Verification
The assertions have three kinds of check:
- Trigger checks assume that the trigger bit changes only through control writes. They check that an accepted trigger is a single-clock pulse that occurs while the bit is high.
- Counter checks assume that the working period and prescaler stay constant between accepted triggers.
- A restart check requires both counters to read zero on the clock after a trigger is accepted.

The stimulus follows a fixed trigger procedure. It keeps every trigger bit low for HOLD_CYC+2 clocks before raising it, and high for HOLD_CYC+4 clocks before measuring. The only exceptions are the deliberate short-low and short-high pulses used to check that triggers are discarded. Between triggers the stimulus leaves the counts alone, except for the deliberate shadow writes that check a running channel ignores them.

// File: rtl/pwm_trig_pkg.sv
package pwm_trig_pkg;
  localparam int unsigned EN_LSB   = 0;
  localparam int unsigned POL_LSB  = 8;
  localparam int unsigned TYP_LSB  = 15;
  localparam int unsigned CTRL_OFF = 'h00;
  localparam int unsigned PER_OFF  = 'h04;
  localparam int unsigned DUTY_OFF = 'h08;
  localparam int unsigned CH_STEP  = 8;
  localparam int unsigned PS_OFF   = 'h24;
endpackage

// File: rtl/pwm_trig_regs.sv
module pwm_trig_regs
  import pwm_trig_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PS_W   = 6,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic [NCH-1:0]              en_o,
  output logic [NCH-1:0]              pol_o,
  output logic [NCH-1:0]              typ_o,
  output logic [NCH-1:0][CNT_W-1:0]   per_o,
  output logic [NCH-1:0][CNT_W-1:0]   duty_o,
  output logic [NCH-1:0][PS_W-1:0]    ps_o
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      pol_o  <= '1;
      typ_o  <= '0;
      per_o  <= '0;
      duty_o <= '0;
      ps_o   <= '0;
    end else if (we_i) begin
      if (hit(addr_i, CTRL_OFF)) begin
        en_o  <= wdata_i[EN_LSB  +: NCH];
        pol_o <= wdata_i[POL_LSB +: NCH];
        typ_o <= wdata_i[TYP_LSB +: NCH];
      end
      if (hit(addr_i, PS_OFF)) begin
        for (int n = 0; n < NCH; n++)
          ps_o[n] <= wdata_i[(NCH-1-n)*PS_W +: PS_W];  // channel 0 in top field
      end
      for (int n = 0; n < NCH; n++) begin
        if (hit(addr_i, PER_OFF  + CH_STEP*n)) per_o[n]  <= wdata_i[CNT_W-1:0];
        if (hit(addr_i, DUTY_OFF + CH_STEP*n)) duty_o[n] <= wdata_i[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit(addr_i, CTRL_OFF)) begin
      rdata_o[EN_LSB  +: NCH] = en_o;
      rdata_o[POL_LSB +: NCH] = pol_o;
      rdata_o[TYP_LSB +: NCH] = typ_o;
    end
    if (hit(addr_i, PS_OFF)) begin
      for (int n = 0; n < NCH; n++)
        rdata_o[(NCH-1-n)*PS_W +: PS_W] = ps_o[n];
    end
    for (int n = 0; n < NCH; n++) begin
      if (hit(addr_i, PER_OFF  + CH_STEP*n)) rdata_o[CNT_W-1:0] = per_o[n];
      if (hit(addr_i, DUTY_OFF + CH_STEP*n)) rdata_o[CNT_W-1:0] = duty_o[n];
    end
  end
endmodule

// File: rtl/pwm_trig_qual.sv
module pwm_trig_qual #(
  parameter int unsigned HOLD_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic apply_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD = CW'(HOLD_CYC);

  logic [CW-1:0] low_cnt, high_cnt;
  logic          armed, done;

  assign apply_o = en_i && armed && (high_cnt == HOLD) && !done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt  <= '0;
      high_cnt <= '0;
      armed    <= 1'b0;
      done     <= 1'b0;
    end else if (!en_i) begin
      if (low_cnt != HOLD) low_cnt <= low_cnt + 1'b1;
      high_cnt <= '0;
      armed    <= 1'b0;
      done     <= 1'b0;
    end else begin
      low_cnt <= '0;
      // qualify the low window on the first high clock
      if (high_cnt == '0) armed <= (low_cnt == HOLD);
      if (high_cnt != HOLD) high_cnt <= high_cnt + 1'b1;
      if (apply_o) done <= 1'b1;
    end
  end

  // R4
  apply_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_o |-> en_i);
  // R4
  apply_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_o |=> !apply_o);
endmodule

// File: rtl/pwm_trig_chan.sv
module pwm_trig_chan #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PS_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             apply_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic             pol_i,
  output logic             out_o
);
  logic [CNT_W-1:0] act_per, act_duty, per_cnt;
  logic [PS_W-1:0]  act_ps, ps_cnt;
  logic             active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_per  <= '0;
      act_duty <= '0;
      act_ps   <= '0;
      ps_cnt   <= '0;
      per_cnt  <= '0;
    end else if (apply_i) begin
      act_per  <= per_i;
      act_duty <= duty_i;
      act_ps   <= ps_i;
      ps_cnt   <= '0;
      per_cnt  <= '0;
    end else if (act_per != '0) begin
      if (ps_cnt == act_ps) begin
        ps_cnt  <= '0;
        per_cnt <= (per_cnt == act_per - 1'b1) ? '0 : per_cnt + 1'b1;
      end else begin
        ps_cnt <= ps_cnt + 1'b1;
      end
    end
  end

  assign active = (act_per != '0) && (per_cnt < act_duty);
  assign out_o  = pol_i ? active : !active;

  // R5
  per_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_per != '0) |-> (per_cnt < act_per) && (ps_cnt <= act_ps));
  // R5
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i |=> (per_cnt == '0) && (ps_cnt == '0));
  // R6
  full_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_per != '0 && act_duty >= act_per) |-> (out_o == pol_i));
  // R7
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_per == '0) |-> (out_o == !pol_i));
endmodule

// File: rtl/pwm_trig_bank.sv
module pwm_trig_bank #(
  parameter int unsigned NCH      = 4,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PS_W     = 6,
  parameter int unsigned HOLD_CYC = 50,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NCH-1:0]    pwm_o,
  output logic [NCH-1:0]    drive_full_o
);
  logic [NCH-1:0]            en, pol, typ, apply;
  logic [NCH-1:0][CNT_W-1:0] per, duty;
  logic [NCH-1:0][PS_W-1:0]  ps;

  pwm_trig_regs #(
    .NCH(NCH), .CNT_W(CNT_W), .PS_W(PS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .en_o(en), .pol_o(pol), .typ_o(typ),
    .per_o(per), .duty_o(duty), .ps_o(ps)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    pwm_trig_qual #(.HOLD_CYC(HOLD_CYC)) u_qual (
      .clk_i, .rst_ni, .en_i(en[n]), .apply_o(apply[n])
    );
    pwm_trig_chan #(.CNT_W(CNT_W), .PS_W(PS_W)) u_chan (
      .clk_i, .rst_ni, .apply_i(apply[n]),
      .per_i(per[n]), .duty_i(duty[n]), .ps_i(ps[n]), .pol_i(pol[n]),
      .out_o(pwm_o[n])
    );
  end

  assign drive_full_o = ~typ;

  // R9
  drive_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(drive_full_o) + $countones(typ) == NCH);
endmodule

// File: tb/tb_pwm_trig_bank.sv
module tb_pwm_trig_bank;
  localparam int HOLD = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm, dfull;

  int errors = 0, checks = 0;
  logic [31:0] ctrl_sh = 32'h0000_0F00;
  logic [31:0] ps_sh = '0;

  always #4 clk = ~clk;  // 125 MHz

  pwm_trig_bank #(.HOLD_CYC(HOLD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pwm_o(pwm), .drive_full_o(dfull)
  );

  // ch, period, duty, prescale, expected active clocks, expected inactive clocks
  localparam int NV = 5;
  localparam int V_CH [NV] = '{0, 1, 2, 3, 0};
  localparam int V_P  [NV] = '{10, 8, 5, 20, 2};
  localparam int V_D  [NV] = '{3, 2, 4, 10, 1};
  localparam int V_S  [NV] = '{0, 2, 1, 0, 3};
  localparam int V_HI [NV] = '{3, 6, 8, 10, 4};
  localparam int V_LO [NV] = '{7, 18, 2, 10, 4};

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = 6'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); addr = 6'(a); #1 d = rdata;
  endtask

  task automatic set_en(input int ch, input bit v);
    ctrl_sh[ch] = v;
    wr(0, ctrl_sh);
  endtask

  task automatic trigger(input int ch);
    set_en(ch, 1'b0);
    repeat (HOLD + 2) @(negedge clk);
    set_en(ch, 1'b1);
    repeat (HOLD + 4) @(negedge clk);
  endtask

  task automatic load(input int ch, input int p, input int d, input int s);
    wr(4 + 8*ch, 32'(p));
    wr(8 + 8*ch, 32'(d));
    ps_sh[(3-ch)*6 +: 6] = 6'(s);
    wr('h24, ps_sh);
  endtask

  // measure one active run and the following inactive run
  task automatic measure(input int ch, input bit act, output int hi, output int lo);
    int t;
    hi = -1; lo = -1; t = 0;
    while (pwm[ch] == act && t < 500) begin @(negedge clk); t++; end
    while (pwm[ch] != act && t < 500) begin @(negedge clk); t++; end
    if (t >= 500) return;
    hi = 0;
    while (pwm[ch] == act && hi < 500) begin @(negedge clk); hi++; end
    lo = 0;
    while (pwm[ch] != act && lo < 500) begin @(negedge clk); lo++; end
  endtask

  task automatic steady(input string req, input int ch, input bit lvl, input int n);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm[ch] != lvl) bad++;
    end
    chk(req, bad, 0);
  endtask

  initial begin
    #(8ns * 190000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int hi, lo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 R7 R9 reset state
    rd(0, r);      chk("R1 ctrl reset", r, 32'h0000_0F00);
    rd(4, r);      chk("R1 period reset", r, 0);
    rd('h24, r);   chk("R1 prescale reset", r, 0);
    chk("R7 outputs idle after reset", pwm, 0);
    chk("R9 full drive after reset", dfull, 4'hF);

    // R5 R2 vector table
    for (int v = 0; v < NV; v++) begin
      load(V_CH[v], V_P[v], V_D[v], V_S[v]);
      trigger(V_CH[v]);
      measure(V_CH[v], 1'b1, hi, lo);
      chk($sformatf("R5 R2 vec%0d active", v), hi, V_HI[v]);
      chk($sformatf("R5 R2 vec%0d inactive", v), lo, V_LO[v]);
    end

    // R2 R1 readback
    rd('h24, r);   chk("R2 prescale packing", r, ps_sh);
    rd('h1C, r);   chk("R1 ch3 period", r, 20);
    rd('h20, r);   chk("R1 ch3 duty", r, 10);
    rd('h28, r);   chk("R1 unmapped", r, 0);

    // R3 shadow write while running with trigger high
    wr('h1C, 32'd6); wr('h20, 32'd3);
    repeat (10) @(negedge clk);
    measure(3, 1'b1, hi, lo);
    chk("R3 running ch keeps active", hi, 10);
    chk("R3 running ch keeps inactive", lo, 10);

    // R4 short low window
    set_en(3, 1'b0); set_en(3, 1'b1);
    repeat (HOLD + 4) @(negedge clk);
    measure(3, 1'b1, hi, lo);
    chk("R4 short low rejected", hi + lo, 20);

    // R4 short high window
    set_en(3, 1'b0);
    repeat (HOLD + 2) @(negedge clk);
    set_en(3, 1'b1);
    repeat (2) @(negedge clk);
    set_en(3, 1'b0);
    repeat (HOLD + 4) @(negedge clk);
    measure(3, 1'b1, hi, lo);
    chk("R4 short high rejected", hi + lo, 20);

    // R4 R3 proper trigger applies shadow
    trigger(3);
    measure(3, 1'b1, hi, lo);
    chk("R4 applied active", hi, 3);
    chk("R4 applied inactive", lo, 3);

    // R6 duty >= period, then duty 0
    load(2, 4, 9, 0); trigger(2);
    steady("R6 duty>=period active", 2, 1'b1, 40);
    load(2, 4, 0, 0); trigger(2);
    steady("R6 duty 0 inactive", 2, 1'b0, 40);

    // R8 inverted polarity on ch1 (8,2,2)
    ctrl_sh[8 + 1] = 1'b0; wr(0, ctrl_sh);
    measure(1, 1'b0, hi, lo);
    chk("R8 inverted active low", hi, 6);
    chk("R8 inverted inactive high", lo, 18);

    // R7 idle with inverted polarity
    load(1, 0, 0, 0); trigger(1);
    steady("R7 idle inverted", 1, 1'b1, 40);
    ctrl_sh[8 + 1] = 1'b1; wr(0, ctrl_sh);
    steady("R7 idle normal", 1, 1'b0, 10);

    // R9 output type
    ctrl_sh[15 + 2] = 1'b1; wr(0, ctrl_sh);
    @(negedge clk);
    chk("R9 drive mode ch2", dfull, 4'b1011);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule